// File: doc/BRIEF.md
# Frame-Rate Exposure and Gain Regulator

This block closes the auto-exposure loop of an image sensor one frame at a time. At every end-of-frame strobe it reads a five-way brightness verdict for the frame just captured. From that verdict it computes the integration time and the digital gain exponent for the next frame and registers them. Integration time is counted in pixel-clock periods. The gain exponent selects a multiplier of 1, 2, 4, 8 or 16.

Small and large errors are corrected by nudging the integration time by 1/64 or 1/8 of its value. A dark frame at an integration time close to a full frame raises the gain by one doubling and halves the integration time in the same update. A bright frame at a very short integration time lowers the gain by one doubling and doubles the integration time. Two enables let the system freeze the exposure loop as a whole, or only the gain.

Top module: `aexp_gain_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, `exposure` becomes EXP_INIT (512 by default) and `gain_exp` becomes 0, which selects x1.
- R2: The `bright` code is 0 for correct, 1 for slightly over, 2 for greatly over, 3 for slightly under and 4 for greatly under. Code 0 and codes 5 to 7 leave both outputs unchanged.
- R3: On a slight error with no gain trade, `exposure` moves by exposure>>6 toward the correct level: up when under, down when over. The move is never less than one count.
- R4: On a great error with no gain trade, `exposure` moves by exposure>>3 toward the correct level. The move is never less than one count.
- R5: After every update, `exposure` stays within EXP_MIN..FRAME_LEN (4..1024 by default). A correction that would leave this range is clamped to the nearest limit.
- R6: The gain goes up in these conditions: the frame is under (code 3 or 4), `agc_en` is high, `gain_exp` is below 4, and `exposure` is above FRAME_LEN*7/8 (896). Then `gain_exp` rises by one and `exposure` is halved in the same update.
- R7: The gain goes down in these conditions: the frame is over (code 1 or 2), `agc_en` is high, `gain_exp` is above 0, and `exposure` is below SHORT_LIMIT (16). Then `gain_exp` falls by one and `exposure` is doubled in the same update.
- R8: `gain_exp` stays within 0..4 and changes by at most one step per update.
- R9: While `aec_en` is low at a strobe, both `exposure` and `gain_exp` hold their values, whatever `agc_en` is.
- R10: While `agc_en` is low and `aec_en` is high, `gain_exp` holds its value and `exposure` still follows R3 to R5.
- R11: Outputs change only on the clock edge at which `frame_end` is high, and the new values are visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_end | input | 1 | One-cycle strobe marking the end of a frame |
| bright | input | 3 | Brightness verdict for the finished frame |
| aec_en | input | 1 | Exposure loop enable; low freezes everything |
| agc_en | input | 1 | Gain trading enable |
| exposure | output | EXP_W (11) | Integration time for the next frame, in pixel clocks |
| gain_exp | output | 3 | Gain exponent, multiplier = 2**gain_exp |

## Verification
The assertions assume that `frame_end` is a clean single-cycle strobe and that `bright`, `aec_en` and `agc_en` are stable and known whenever the strobe is high. The bench drives all inputs on the falling clock edge. It raises the strobe for exactly one cycle, and each new setting is presented together with the strobe. The trade checks rest on two further assumptions: the thresholds default to 896 and 16, and the exposure value never leaves its range. The bench reaches the trade regions only through long runs of legal verdicts, never by forcing state.

// File: rtl/expg_pkg.sv
// Shared definitions for the exposure/gain regulator.
// Assumes the brightness verdict arrives as a 3-bit code; unused codes mean "correct".
package expg_pkg;

    typedef enum logic [2:0] {
        BR_OK      = 3'd0,
        BR_OVER_S  = 3'd1,
        BR_OVER_G  = 3'd2,
        BR_UNDER_S = 3'd3,
        BR_UNDER_G = 3'd4
    } bright_e;

    // True when the verdict asks for more light.
    function automatic logic is_dark(input logic [2:0] code);
        return (code == BR_UNDER_S) || (code == BR_UNDER_G);
    endfunction

    // True when the verdict asks for less light.
    function automatic logic is_light(input logic [2:0] code);
        return (code == BR_OVER_S) || (code == BR_OVER_G);
    endfunction

    // True when the error is the large kind.
    function automatic logic is_great(input logic [2:0] code);
        return (code == BR_OVER_G) || (code == BR_UNDER_G);
    endfunction

endpackage

// File: rtl/expg_step_calc.sv
// Fine/coarse exposure correction: moves the current exposure by 1/64 or 1/8
// of its value (minimum one count) and clamps into [EXP_MIN, FRAME_LEN].
// Assumes the current value is already in range.
module expg_step_calc #(
    parameter int EXP_W      = 11,
    parameter int FRAME_LEN  = 1024,
    parameter int EXP_MIN    = 4,
    parameter int FINE_SHIFT = 6,
    parameter int COARSE_SH  = 3
) (
    input  logic [EXP_W-1:0] cur_exp,
    input  logic             go_up,
    input  logic             coarse,
    output logic [EXP_W-1:0] new_exp
);
    localparam logic [EXP_W:0] MAX_W = (EXP_W+1)'(FRAME_LEN);
    localparam logic [EXP_W:0] MIN_W = (EXP_W+1)'(EXP_MIN);

    logic [EXP_W-1:0] raw_step;
    logic [EXP_W-1:0] step;
    logic [EXP_W:0]   sum;

    // Select step size and enforce the one-count floor.
    always_comb begin
        raw_step = coarse ? (cur_exp >> COARSE_SH) : (cur_exp >> FINE_SHIFT);
        step     = (raw_step == '0) ? EXP_W'(1) : raw_step;
    end

    // Apply the step in the requested direction and clamp.
    always_comb begin
        sum = '0;
        if (go_up) begin
            sum = {1'b0, cur_exp} + {1'b0, step};
            new_exp = (sum > MAX_W) ? MAX_W[EXP_W-1:0] : sum[EXP_W-1:0];
        end else if ({1'b0, cur_exp} < ({1'b0, step} + MIN_W)) begin
            new_exp = MIN_W[EXP_W-1:0];
        end else begin
            new_exp = cur_exp - step;
        end
    end

endmodule

// File: rtl/expg_trade.sv
// Gain/exposure trade decision: when dark near the longest integration it
// doubles gain and halves exposure; when bright near the shortest it halves
// gain and doubles exposure. Result is clamped to the legal exposure range.
// Assumes cur_gain never exceeds GAIN_MAX.
module expg_trade #(
    parameter int EXP_W       = 11,
    parameter int GAIN_W      = 3,
    parameter int GAIN_MAX    = 4,
    parameter int FRAME_LEN   = 1024,
    parameter int EXP_MIN     = 4,
    parameter int HIGH_LIMIT  = 896,
    parameter int SHORT_LIMIT = 16
) (
    input  logic [EXP_W-1:0]  cur_exp,
    input  logic [GAIN_W-1:0] cur_gain,
    input  logic              dark,
    input  logic              light,
    input  logic              agc_on,
    output logic              up_trade,
    output logic              down_trade,
    output logic [EXP_W-1:0]  traded_exp
);
    localparam logic [EXP_W:0] MAX_W = (EXP_W+1)'(FRAME_LEN);
    localparam logic [EXP_W-1:0] MIN_V = EXP_W'(EXP_MIN);

    logic [EXP_W-1:0] halved;
    logic [EXP_W:0]   doubled;

    // Decide whether this update trades gain against integration time.
    always_comb begin
        up_trade   = agc_on && dark  && (cur_gain < GAIN_W'(GAIN_MAX))
                     && (cur_exp > EXP_W'(HIGH_LIMIT));
        down_trade = agc_on && light && (cur_gain != '0)
                     && (cur_exp < EXP_W'(SHORT_LIMIT));
    end

    // Compute the rescaled exposure for either trade direction.
    always_comb begin
        halved  = cur_exp >> 1;
        doubled = {cur_exp, 1'b0};
        if (up_trade)
            traded_exp = (halved < MIN_V) ? MIN_V : halved;
        else
            traded_exp = (doubled > MAX_W) ? MAX_W[EXP_W-1:0] : doubled[EXP_W-1:0];
    end

endmodule

// File: rtl/aexp_gain_loop.sv
// Frame-rate exposure and gain regulator. At each frame_end strobe it
// registers the integration time and gain exponent for the next frame.
// Assumes frame_end is a one-cycle strobe and the other inputs are valid with it.
module aexp_gain_loop
    import expg_pkg::*;
#(
    parameter int FRAME_LEN   = 1024,
    parameter int EXP_MIN     = 4,
    parameter int EXP_INIT    = 512,
    parameter int SHORT_LIMIT = 16,
    parameter int GAIN_MAX    = 4,
    parameter int EXP_W       = $clog2(FRAME_LEN + 1),
    parameter int GAIN_W      = $clog2(GAIN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [2:0]        bright,
    input  logic              aec_en,
    input  logic              agc_en,
    output logic [EXP_W-1:0]  exposure,
    output logic [GAIN_W-1:0] gain_exp
);
    localparam int HIGH_LIMIT = FRAME_LEN - (FRAME_LEN / 8);

    logic             dark, light, coarse;
    logic             up_trade, down_trade;
    logic [EXP_W-1:0] stepped_exp, traded_exp;
    logic [EXP_W-1:0] exp_nxt;
    logic [GAIN_W-1:0] gain_nxt;

    // Decode the verdict.
    always_comb begin
        dark   = is_dark(bright);
        light  = is_light(bright);
        coarse = is_great(bright);
    end

    expg_step_calc #(
        .EXP_W     (EXP_W),
        .FRAME_LEN (FRAME_LEN),
        .EXP_MIN   (EXP_MIN),
        .FINE_SHIFT(6),
        .COARSE_SH (3)
    ) u_step (
        .cur_exp (exposure),
        .go_up   (dark),
        .coarse  (coarse),
        .new_exp (stepped_exp)
    );

    expg_trade #(
        .EXP_W      (EXP_W),
        .GAIN_W     (GAIN_W),
        .GAIN_MAX   (GAIN_MAX),
        .FRAME_LEN  (FRAME_LEN),
        .EXP_MIN    (EXP_MIN),
        .HIGH_LIMIT (HIGH_LIMIT),
        .SHORT_LIMIT(SHORT_LIMIT)
    ) u_trade (
        .cur_exp   (exposure),
        .cur_gain  (gain_exp),
        .dark      (dark),
        .light     (light),
        .agc_on    (agc_en),
        .up_trade  (up_trade),
        .down_trade(down_trade),
        .traded_exp(traded_exp)
    );

    // Choose the next control values for this frame boundary.
    always_comb begin
        exp_nxt  = exposure;
        gain_nxt = gain_exp;
        if (frame_end && aec_en && (dark || light)) begin
            if (up_trade) begin
                exp_nxt  = traded_exp;
                gain_nxt = gain_exp + GAIN_W'(1);
            end else if (down_trade) begin
                exp_nxt  = traded_exp;
                gain_nxt = gain_exp - GAIN_W'(1);
            end else begin
                exp_nxt  = stepped_exp;
            end
        end
    end

    // Hold the control values applied to the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exposure <= EXP_W'(EXP_INIT);
            gain_exp <= '0;
        end else begin
            exposure <= exp_nxt;
            gain_exp <= gain_nxt;
        end
    end

endmodule

// File: rtl/expg_chk.sv
// Property checker for the exposure/gain regulator, bound to the top.
// Assumes frame_end is a single-cycle strobe with valid companion inputs.
module expg_chk #(
    parameter int FRAME_LEN = 1024,
    parameter int EXP_MIN   = 4,
    parameter int GAIN_MAX  = 4,
    parameter int EXP_W     = 11,
    parameter int GAIN_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic [2:0]        bright,
    input logic              aec_en,
    input logic              agc_en,
    input logic [EXP_W-1:0]  exposure,
    input logic [GAIN_W-1:0] gain_exp
);
    logic live;

    // Marks that one full cycle has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    a_r1_reset_vals: assert property (@(posedge clk)
        !rst_n |=> (gain_exp == '0));

    a_r5_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (exposure >= EXP_W'(EXP_MIN)) && (exposure <= EXP_W'(FRAME_LEN)));

    a_r8_gain_range: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (gain_exp <= GAIN_W'(GAIN_MAX)));

    a_r8_gain_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> (gain_exp == $past(gain_exp)) || (gain_exp == $past(gain_exp) + GAIN_W'(1))
                 || (gain_exp + GAIN_W'(1) == $past(gain_exp)));

    a_r11_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !frame_end) |=> $stable(exposure) && $stable(gain_exp));

    a_r2_ok_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && frame_end && (bright == 3'd0)) |=> $stable(exposure) && $stable(gain_exp));

    a_r9_aec_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (live && frame_end && !aec_en) |=> $stable(exposure) && $stable(gain_exp));

    a_r10_agc_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (live && frame_end && !agc_en) |=> $stable(gain_exp));

    a_r6_up_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (live && frame_end) ##1 (gain_exp == $past(gain_exp) + GAIN_W'(1))
        |-> (exposure == ($past(exposure) >> 1)));

    a_r7_down_doubles: assert property (@(posedge clk) disable iff (!rst_n)
        (live && frame_end) ##1 (gain_exp + GAIN_W'(1) == $past(gain_exp))
        |-> (exposure == {$past(exposure), 1'b0}));

endmodule

bind aexp_gain_loop expg_chk #(
    .FRAME_LEN(FRAME_LEN),
    .EXP_MIN  (EXP_MIN),
    .GAIN_MAX (GAIN_MAX),
    .EXP_W    (EXP_W),
    .GAIN_W   (GAIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_end(frame_end),
    .bright   (bright),
    .aec_en   (aec_en),
    .agc_en   (agc_en),
    .exposure (exposure),
    .gain_exp (gain_exp)
);

// File: tb/aexp_gain_loop_tb.sv
// Directed bench for the exposure/gain regulator; one task per scenario.
module aexp_gain_loop_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_end = 1'b0;
    logic [2:0]  bright = 3'd0;
    logic        aec_en = 1'b1;
    logic        agc_en = 1'b1;
    logic [10:0] exposure;
    logic [2:0]  gain_exp;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    aexp_gain_loop u_dut (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .bright(bright),
        .aec_en(aec_en), .agc_en(agc_en), .exposure(exposure), .gain_exp(gain_exp)
    );

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // One frame boundary: strobe for one cycle, sample after the update edge.
    task automatic frame(input logic [2:0] code, input logic aec, input logic agc);
        @(negedge clk);
        frame_end = 1'b1; bright = code; aec_en = aec; agc_en = agc;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 exposure", exposure, 512);
        check("R1 gain", gain_exp, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_hold_cases();
        frame(3'd0, 1, 1);
        check("R2 correct code exposure", exposure, 512);
        frame(3'd6, 1, 1);
        check("R2 unused code exposure", exposure, 512);
        // R11: verdict changes without strobe do nothing
        @(negedge clk); bright = 3'd4;
        repeat (3) @(negedge clk);
        check("R11 no strobe", exposure, 512);
    endtask

    task automatic t_steps();
        frame(3'd3, 1, 1);
        check("R3 slight under", exposure, 520);
        frame(3'd4, 1, 1);
        check("R4 great under", exposure, 585);
        frame(3'd1, 1, 1);
        check("R3 slight over", exposure, 576);
        frame(3'd2, 1, 1);
        check("R4 great over", exposure, 504);
    endtask

    task automatic t_freeze();
        frame(3'd4, 0, 1);
        check("R9 aec low exposure", exposure, 504);
        check("R9 aec low gain", gain_exp, 0);
        // climb to the ceiling with gain frozen
        for (int i = 0; i < 7; i++) frame(3'd4, 1, 0);
        check("R5 clamp at max", exposure, 1024);
        check("R10 agc low gain", gain_exp, 0);
    endtask

    task automatic t_trade_up();
        frame(3'd3, 1, 1);
        check("R6 gain up", gain_exp, 1);
        check("R6 exposure halved", exposure, 512);
        for (int i = 0; i < 60; i++) frame(3'd4, 1, 1);
        check("R8 gain ceiling", gain_exp, 4);
        check("R5 max after trades", exposure, 1024);
    endtask

    task automatic t_trade_down();
        for (int i = 0; i < 70; i++) frame(3'd2, 1, 0);
        check("R5 clamp at min", exposure, 4);
        check("R10 gain kept", gain_exp, 4);
        frame(3'd1, 1, 1);
        check("R7 gain down", gain_exp, 3);
        check("R7 exposure doubled", exposure, 8);
        frame(3'd3, 1, 1);
        check("R3 one count floor", exposure, 9);
        check("R8 gain steady", gain_exp, 3);
        frame(3'd1, 0, 1);
        check("R9 both frozen exposure", exposure, 9);
        check("R9 both frozen gain", gain_exp, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hold_cases();
        t_steps();
        t_freeze();
        t_trade_up();
        t_trade_down();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule